// File: doc/BRIEF.md
# Serial Clock-Synthesizer Configuration Writer

This block sits on the host side of a board and loads one 160-bit configuration word into an external clock synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. A single-cycle start pulse on the system clock latches the word. The block then shifts the word out starting with the most significant bit, pulses the load strobe, and releases a power-down line that it held low during loading, so the synthesizer outputs stay off while they are being programmed.

The receiving latch lets data through whenever the load strobe is high, so the strobe stays low for every serial clock edge. Every analog timing limit of the link is a nanosecond parameter: setup, hold, minimum serial clock period, gap before the strobe, strobe width and output lock time. Each one is converted to whole system-clock cycles and rounded up. Busy covers the whole transfer. A done pulse marks its end. A locked flag rises once the synthesizer has had its settling time.

Top module: `synth_cfg_loader`

## Requirements
- R1: After an accepted start, exactly WORD_BITS serial clock rising edges occur. At the k-th edge (k = 1..WORD_BITS), dataOut equals bit WORD_BITS-k of the word latched at start, so bit 159 goes first by default.
- R2: dataOut stays unchanged for at least the setup cycles before each serial clock rising edge. It changes only while sclkOut is low, and no sooner than the hold cycles after the preceding rising edge.
- R3: Consecutive serial clock rising edges are at least the minimum-period cycle count apart. The minimum period is the ceiling of 1e6 / (SCLK_MAX_KHZ * CLK_NS) cycles.
- R4: strobeOut is low at every serial clock rising edge and whenever sclkOut is high.
- R5: strobeOut rises only after sclkOut has been low for at least the gap cycles following the last bit, and only once all WORD_BITS edges have been sent.
- R6: strobeOut stays high for at least the pulse-width cycles.
- R7: pdnOut goes low in the cycle a start is accepted. It stays low while bits shift and while strobeOut is high. It returns high in the same cycle that strobeOut falls.
- R8: busyOut rises when a start is accepted and falls in the same cycle that strobeOut falls. doneOut is high for exactly that one cycle.
- R9: lockedOut rises exactly the lock-wait cycle count after strobeOut falls. It is low whenever busyOut is high, and an accepted start clears it.
- R10: A start pulse while busyOut is high is ignored. The transfer in progress completes unchanged, with its own data and edge count.
- R11: While reset is asserted, the outputs are sclkOut=0, dataOut=0, strobeOut=0, pdnOut=1, busyOut=0, doneOut=0 and lockedOut=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startIn | input | 1 | Start request, one cycle; accepted only when not busy |
| cfgWord | input | WORD_BITS | Configuration word, captured when a start is accepted |
| sclkOut | output | 1 | Serial clock to the synthesizer |
| dataOut | output | 1 | Serial data, most significant bit first |
| strobeOut | output | 1 | Load strobe; the target latch is open while high |
| pdnOut | output | 1 | Power-down control, low keeps the target outputs off |
| busyOut | output | 1 | High from start acceptance until the strobe pulse ends |
| doneOut | output | 1 | One-cycle pulse when the transfer ends |
| lockedOut | output | 1 | High once the lock wait after the strobe has elapsed |

## Verification
The hardest cases to reach from the ports are two start requests that collide with the busy window. The stimulus fires a second start, carrying a different word, in the middle of the shifting phase. It also starts a new frame during the lock wait of the previous one, before locked has risen. Both cases are caught by a scoreboard that pops one expected bit per serial clock edge. The same monitor also measures every timing interval from the outputs alone, so a stray reload or a shortened gap shows up as a data mismatch, a wrong edge count or an interval that is too short.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;

  // Strobes sent from the sequencer to the datapath.
  typedef struct packed {
    logic load;       // capture word, start a frame
    logic shift;      // advance to the next bit
    logic sclkSet;
    logic sclkClr;
    logic strobeSet;
    logic strobeClr;
    logic pdnSet;
  } dpCtl_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_GAP,
    PH_PULSE,
    PH_SETTLE
  } phase_e;

  function automatic int ceilDiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/synth_cfg_dp.sv
module synth_cfg_dp
  import synth_cfg_pkg::*;
#(
  parameter int WORD_BITS = 160
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [WORD_BITS-1:0] wordIn,
  output logic                 sclkOut,
  output logic                 dataOut,
  output logic                 strobeOut,
  output logic                 pdnOut
);

  localparam int MSB = WORD_BITS - 1;

  logic [WORD_BITS-1:0] shiftReg;
  logic                 sclkReg;
  logic                 strobeReg;
  logic                 pdnReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      sclkReg   <= 1'b0;
      strobeReg <= 1'b0;
      pdnReg    <= 1'b1;
    end else begin
      if (ctl.load) begin
        shiftReg  <= wordIn;
        sclkReg   <= 1'b0;
        strobeReg <= 1'b0;
        pdnReg    <= 1'b0;
      end else begin
        if (ctl.shift)     shiftReg  <= {shiftReg[MSB-1:0], 1'b0};
        if (ctl.sclkSet)   sclkReg   <= 1'b1;
        if (ctl.sclkClr)   sclkReg   <= 1'b0;
        if (ctl.strobeSet) strobeReg <= 1'b1;
        if (ctl.strobeClr) strobeReg <= 1'b0;
        if (ctl.pdnSet)    pdnReg    <= 1'b1;
      end
    end
  end

  assign sclkOut   = sclkReg;
  assign dataOut   = shiftReg[MSB];
  assign strobeOut = strobeReg;
  assign pdnOut    = pdnReg;

  // R4: the target latch must stay closed while the clock is high
  p_strobe_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    sclkReg |-> !strobeReg);

  // R7: outputs stay powered down for as long as the strobe is high
  p_pdn_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobeReg |-> !pdnReg);

  // R2: data does not move while the serial clock stays high
  p_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sclkReg && $past(sclkReg)) |-> $stable(shiftReg[MSB]));

endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int WORD_BITS = 160,
  parameter int LOW_CYC   = 2,
  parameter int HIGH_CYC  = 2,
  parameter int GAP_CYC   = 1,
  parameter int PULSE_CYC = 4,
  parameter int LOCK_CYC  = 1000
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   startIn,
  output dpCtl_t ctl,
  output logic   busyOut,
  output logic   doneOut,
  output logic   lockedOut
);

  localparam int MAX_CYC = maxOf(maxOf(maxOf(LOW_CYC, HIGH_CYC), maxOf(GAP_CYC, PULSE_CYC)), LOCK_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = $clog2(WORD_BITS);

  phase_e           state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limitM1;
  logic [BIT_W-1:0] bitCnt;
  logic             busy;
  logic             done;
  logic             locked;
  logic             accept;
  logic             phaseEnd;
  logic             lastBit;

  assign accept  = startIn && !busy;
  assign lastBit = (bitCnt == BIT_W'(WORD_BITS - 1));

  always_comb begin
    case (state)
      PH_LOW:    limitM1 = CNT_W'(LOW_CYC - 1);
      PH_HIGH:   limitM1 = CNT_W'(HIGH_CYC - 1);
      PH_GAP:    limitM1 = CNT_W'(GAP_CYC - 1);
      PH_PULSE:  limitM1 = CNT_W'(PULSE_CYC - 1);
      PH_SETTLE: limitM1 = CNT_W'(LOCK_CYC - 1);
      default:   limitM1 = '0;
    endcase
  end

  assign phaseEnd = (cnt == limitM1);

  always_comb begin
    ctl = '0;
    if (accept) begin
      ctl.load = 1'b1;
    end else begin
      case (state)
        PH_LOW:   if (phaseEnd) ctl.sclkSet = 1'b1;
        PH_HIGH:  if (phaseEnd) begin
                    ctl.sclkClr = 1'b1;
                    ctl.shift   = !lastBit;
                  end
        PH_GAP:   if (phaseEnd) ctl.strobeSet = 1'b1;
        PH_PULSE: if (phaseEnd) begin
                    ctl.strobeClr = 1'b1;
                    ctl.pdnSet    = 1'b1;
                  end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= PH_IDLE;
      cnt    <= '0;
      bitCnt <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
      locked <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        state  <= PH_LOW;
        cnt    <= '0;
        bitCnt <= '0;
        busy   <= 1'b1;
        locked <= 1'b0;
      end else begin
        case (state)
          PH_LOW: begin
            if (phaseEnd) begin
              state <= PH_HIGH;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          PH_HIGH: begin
            if (phaseEnd) begin
              cnt <= '0;
              if (lastBit) state <= PH_GAP;
              else begin
                state  <= PH_LOW;
                bitCnt <= bitCnt + 1'b1;
              end
            end else cnt <= cnt + 1'b1;
          end
          PH_GAP: begin
            if (phaseEnd) begin
              state <= PH_PULSE;
              cnt   <= '0;
            end else cnt <= cnt + 1'b1;
          end
          PH_PULSE: begin
            if (phaseEnd) begin
              state <= PH_SETTLE;
              cnt   <= '0;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          PH_SETTLE: begin
            if (phaseEnd) begin
              state  <= PH_IDLE;
              cnt    <= '0;
              locked <= 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          default: begin
            state <= PH_IDLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  assign busyOut   = busy;
  assign doneOut   = done;
  assign lockedOut = locked;

  // R8: the end of busy is always marked by done
  p_done_at_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R8: done lasts a single cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: locked never overlaps a transfer
  p_locked_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> !busy);

  // R10: a start during a transfer does not restart the bit count
  p_ignore_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startIn && bitCnt != '0) |=> (bitCnt != '0));

endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
  import synth_cfg_pkg::*;
#(
  parameter int WORD_BITS    = 160,
  parameter int CLK_NS       = 10,
  parameter int SETUP_NS     = 10,
  parameter int HOLD_NS      = 10,
  parameter int GAP_NS       = 10,
  parameter int PULSE_NS     = 40,
  parameter int SCLK_MAX_KHZ = 30000,
  parameter int LOCK_NS      = 10_000_000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startIn,
  input  logic [WORD_BITS-1:0] cfgWord,
  output logic                 sclkOut,
  output logic                 dataOut,
  output logic                 strobeOut,
  output logic                 pdnOut,
  output logic                 busyOut,
  output logic                 doneOut,
  output logic                 lockedOut
);

  localparam int SETUP_CYC  = maxOf(1, ceilDiv(SETUP_NS, CLK_NS));
  localparam int HOLD_CYC   = maxOf(1, ceilDiv(HOLD_NS, CLK_NS));
  localparam int PERIOD_CYC = maxOf(2, ceilDiv(1_000_000, SCLK_MAX_KHZ * CLK_NS));
  localparam int LOW_CYC    = maxOf(SETUP_CYC, ceilDiv(PERIOD_CYC, 2));
  localparam int HIGH_CYC   = maxOf(HOLD_CYC, PERIOD_CYC - LOW_CYC);
  localparam int GAP_CYC    = maxOf(1, ceilDiv(GAP_NS, CLK_NS));
  localparam int PULSE_CYC  = maxOf(1, ceilDiv(PULSE_NS, CLK_NS));
  localparam int LOCK_CYC   = maxOf(1, ceilDiv(LOCK_NS, CLK_NS));

  dpCtl_t ctl;

  synth_cfg_ctrl #(
    .WORD_BITS (WORD_BITS),
    .LOW_CYC   (LOW_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .GAP_CYC   (GAP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .LOCK_CYC  (LOCK_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .ctl       (ctl),
    .busyOut   (busyOut),
    .doneOut   (doneOut),
    .lockedOut (lockedOut)
  );

  synth_cfg_dp #(
    .WORD_BITS (WORD_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .wordIn    (cfgWord),
    .sclkOut   (sclkOut),
    .dataOut   (dataOut),
    .strobeOut (strobeOut),
    .pdnOut    (pdnOut)
  );

endmodule

// File: tb/synth_cfg_loader_tb.sv
module synth_cfg_loader_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WB         = 160;
  // Expected cycle counts at 10 ns per cycle, from the nanosecond limits
  localparam int SETUP_CYC  = 1;    // 10 ns
  localparam int HOLD_CYC   = 1;    // 10 ns
  localparam int PERIOD_CYC = 4;    // ceil(33.3 ns / 10 ns)
  localparam int GAP_CYC    = 1;    // 10 ns
  localparam int PULSE_CYC  = 4;    // 40 ns
  localparam int LOCK_CYC   = 200;  // 2000 ns lock wait in this bench

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startIn = 1'b0;
  logic [WB-1:0] cfgWord = '0;
  logic sclkOut, dataOut, strobeOut, pdnOut, busyOut, doneOut, lockedOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_cfg_loader #(.WORD_BITS(WB), .CLK_NS(CLK_PERIOD), .LOCK_NS(2000)) u_dut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .cfgWord(cfgWord),
    .sclkOut(sclkOut), .dataOut(dataOut), .strobeOut(strobeOut), .pdnOut(pdnOut),
    .busyOut(busyOut), .doneOut(doneOut), .lockedOut(lockedOut)
  );

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  bit expQ[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendWord(input logic [WB-1:0] w);
    wait (!busyOut);
    @(negedge clk);
    for (int i = WB - 1; i >= 0; i--) expQ.push_back(w[i]);
    cfgWord = w;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // Monitor: sampled between edges
  int  sampleNo = 0;
  bit  armed = 1'b0;
  logic pSclk = 0, pData = 0, pStrobe = 0, pPdn = 1, pBusy = 0, pLocked = 0;
  int  dataAge = 0, lastRise = -1000, lastFall = -1000;
  int  strobeRise = 0, strobeFall = 0, frameRises = 0;

  always @(negedge clk) begin
    if (rstN) begin
      sampleNo++;
      dataAge = (dataOut != pData) ? 1 : dataAge + 1;
      if (armed) begin
        if (busyOut && !pBusy) begin
          frameRises = 0;
          chk(!lockedOut, "R9 locked cleared at start", lockedOut, 0);
          chk(!pdnOut, "R7 pdn low at start", pdnOut, 0);
        end
        if (sclkOut && !pSclk) begin
          frameRises++;
          if (expQ.size() == 0) chk(0, "R1 extra sclk edge", frameRises, WB);
          else begin
            bit e;
            e = expQ.pop_front();
            chk(dataOut == e, "R1 data bit", dataOut, e);
          end
          chk(dataAge - 1 >= SETUP_CYC, "R2 setup", dataAge - 1, SETUP_CYC);
          if (frameRises > 1)
            chk(sampleNo - lastRise >= PERIOD_CYC, "R3 sclk period", sampleNo - lastRise, PERIOD_CYC);
          chk(!strobeOut, "R4 strobe low at edge", strobeOut, 0);
          chk(!pdnOut, "R7 pdn low while shifting", pdnOut, 0);
          lastRise = sampleNo;
        end
        if (!sclkOut && pSclk) lastFall = sampleNo;
        if (dataOut != pData && busyOut) begin
          chk(!sclkOut, "R2 data change while sclk low", sclkOut, 0);
          chk(sampleNo - lastRise >= HOLD_CYC, "R2 hold", sampleNo - lastRise, HOLD_CYC);
        end
        if (sclkOut) chk(!strobeOut, "R4 strobe low while sclk high", strobeOut, 0);
        if (strobeOut && !pStrobe) begin
          chk(sampleNo - lastFall >= GAP_CYC, "R5 gap before strobe", sampleNo - lastFall, GAP_CYC);
          chk(frameRises == WB, "R5 all bits before strobe", frameRises, WB);
          chk(!sclkOut, "R5 sclk low at strobe", sclkOut, 0);
          strobeRise = sampleNo;
        end
        if (!strobeOut && pStrobe) begin
          chk(sampleNo - strobeRise >= PULSE_CYC, "R6 strobe width", sampleNo - strobeRise, PULSE_CYC);
          chk(pdnOut, "R7 pdn released with strobe fall", pdnOut, 1);
          chk(!busyOut, "R8 busy falls with strobe", busyOut, 0);
          chk(doneOut, "R8 done with strobe fall", doneOut, 1);
          strobeFall = sampleNo;
        end
        if (pdnOut && !pPdn) chk(pStrobe, "R7 pdn rises only after strobe high", pStrobe, 1);
        if (doneOut) chk(!strobeOut && pStrobe, "R8 done only at strobe fall", pStrobe, 1);
        if (lockedOut && !pLocked)
          chk(sampleNo - strobeFall == LOCK_CYC, "R9 lock wait", sampleNo - strobeFall, LOCK_CYC);
        if (busyOut) chk(!lockedOut, "R9 locked low while busy", lockedOut, 0);
      end
      pSclk = sclkOut; pData = dataOut; pStrobe = strobeOut;
      pPdn = pdnOut; pBusy = busyOut; pLocked = lockedOut;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [WB-1:0] wordA, wordB, wordC;
    wordA = {5{32'hA5C3_0F96}};
    wordB = ~wordA;
    wordC = (160'h1 << 159) | 160'h1;

    repeat (3) @(negedge clk);
    // R11: reset state
    chk(sclkOut == 0, "R11 sclk reset", sclkOut, 0);
    chk(dataOut == 0, "R11 data reset", dataOut, 0);
    chk(strobeOut == 0, "R11 strobe reset", strobeOut, 0);
    chk(pdnOut == 1, "R11 pdn reset", pdnOut, 1);
    chk(busyOut == 0 && doneOut == 0, "R11 busy/done reset", busyOut, 0);
    chk(lockedOut == 0, "R11 locked reset", lockedOut, 0);
    rstN = 1'b1;
    armed = 1'b1;
    @(negedge clk);

    // Frame 1 with an ignored start in the middle (R10)
    sendWord(wordA);
    repeat (100) @(negedge clk);
    cfgWord = wordB;
    startIn = 1'b1;
    @(negedge clk);
    startIn = 1'b0;
    chk(busyOut, "R10 still busy after ignored start", busyOut, 1);
    wait (doneOut);
    @(negedge clk);
    chk(frameRises == WB, "R10 edge count unchanged", frameRises, WB);
    chk(expQ.size() == 0, "R1 frame 1 fully sent", expQ.size(), 0);
    repeat (5) @(negedge clk);
    chk(!lockedOut, "R9 not locked before wait elapses", lockedOut, 0);

    // Frame 2 started during the lock wait of frame 1
    sendWord({WB{1'b1}});
    wait (lockedOut);
    @(negedge clk);
    chk(expQ.size() == 0, "R1 frame 2 fully sent", expQ.size(), 0);
    repeat (10) @(negedge clk);

    // Frame 3 after lock: start clears locked
    sendWord(wordC);
    chk(!lockedOut, "R9 start clears locked", lockedOut, 0);
    wait (lockedOut);
    @(negedge clk);
    chk(expQ.size() == 0, "R1 frame 3 fully sent", expQ.size(), 0);
    chk(pdnOut && !busyOut, "R7 idle after frame", pdnOut, 1);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule